// File: doc/BRIEF.md
# Row-Buffered Page-Mode DRAM Array Model

This block is a clocked, synthesizable stand-in for a small dynamic memory device. Storage is a grid of 4 rows by 4 columns of 8-bit words. Word (i,j) sits at row i, column j. A narrow shared address bus carries first a row index and then a column index. Two active-low strobes tell the block which index is on the bus.

Pulling the row strobe low opens the row on the bus. The whole row is copied into an internal row buffer. Each falling column strobe that follows selects one word of that buffer, and the row stays open while the row strobe stays low. With the write enable high, the word is overwritten in the buffer; otherwise it is driven out. The array row is refreshed from the buffer when the row strobe rises, so an open row may take any number of column accesses, as in page-mode parts.

A column strobe that arrives with no open row does nothing except set a sticky protocol-error flag.

Top module: `dram_page_array`

## Requirements
- R1: After reset `rdata_o` is 0, `proto_err_o` is 0 and every stored word reads as 0.
- R2: Both strobes are sampled on the rising clock edge. On the first edge where `row_strobe_ni` is low while no row is open, the row index on `addr_i` is latched and that row is copied into the row buffer.
- R3: `rdata_o` is 0 in the cycle after any edge that samples `col_strobe_ni` high.
- R4: A column strobe is accepted on an edge that samples `col_strobe_ni` low when the previous edge sampled it high, a row is open and `row_strobe_ni` is low. When `we_i` is 0, the buffered word at the column index on `addr_i` appears on `rdata_o` from the cycle after that edge.
- R5: While one row stays open, any number of column strobes may be accepted, each with a new column index, and no new row activation is needed.
- R6: An accepted column strobe with `we_i` high replaces the addressed word of the row buffer with `wdata_i`. The new value is shown on `rdata_o` while the strobe is held.
- R7: On the first edge that samples `row_strobe_ni` high while a row is open, the buffer is written back to that row and the row closes. Written data is then returned after the row is reopened.
- R8: A write changes only the addressed word. Other words of the same row and all other rows keep their contents.
- R9: A column strobe edge that is not accepted leaves storage and `rdata_o` unchanged and sets `proto_err_o`.
- R10: `proto_err_o` stays 1 until reset.
- R11: While the column strobe is held low, `rdata_o` stays on the latched column even if `addr_i` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| row_strobe_ni | input | 1 | Row strobe, active low |
| col_strobe_ni | input | 1 | Column strobe, active low |
| addr_i | input | 2 | Multiplexed row / column index |
| we_i | input | 1 | Write enable for a column access |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, 0 when no column is active |
| proto_err_o | output | 1 | Sticky flag for a column strobe with no open row |

## Verification
Every word is first filled with a value unique to its row and column. All rows are then read back in page mode, four column strobes per activation. This separates a wrong row from a wrong column and shows whether the data survived the row close. A single word is then overwritten and both the row it sits in and a neighbouring row are reread, which exposes a write that spills into other words. A column strobe with write enable and no open row is followed by a read of the targeted word; this shows whether the stray strobe left storage untouched, and the error flag is checked both there and afterwards. A held strobe with a changing address tells a latched column from a live one.

// File: rtl/dram_page_pkg.sv
package dram_page_pkg;
  typedef enum logic {
    ROW_IDLE = 1'b0,
    ROW_OPEN = 1'b1
  } row_state_e;

  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/dram_cell_array.sv
module dram_cell_array #(
  parameter int unsigned ROWS  = 4,
  parameter int unsigned COLS  = 4,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned ROW_W = dram_page_pkg::idx_w(ROWS),
  localparam int unsigned LINE_W = COLS * WIDTH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ROW_W-1:0]  rd_row_i,
  output logic [LINE_W-1:0] rd_line_o,
  input  logic              wb_en_i,
  input  logic [ROW_W-1:0]  wb_row_i,
  input  logic [LINE_W-1:0] wb_line_i
);
  logic [LINE_W-1:0] mem_q [ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                       mem_q[r] <= '0;
      else if (wb_en_i && (wb_row_i == ROW_W'(r)))       mem_q[r] <= wb_line_i;
    end
  end

  assign rd_line_o = mem_q[rd_row_i];
endmodule

// File: rtl/dram_row_buffer.sv
module dram_row_buffer #(
  parameter int unsigned COLS  = 4,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned COL_W = dram_page_pkg::idx_w(COLS),
  localparam int unsigned LINE_W = COLS * WIDTH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_en_i,
  input  logic [LINE_W-1:0] load_line_i,
  input  logic              wr_en_i,
  input  logic [COL_W-1:0]  wr_col_i,
  input  logic [WIDTH-1:0]  wr_data_i,
  input  logic [COL_W-1:0]  rd_col_i,
  output logic [WIDTH-1:0]  rd_data_o,
  output logic [LINE_W-1:0] line_o
);
  logic [WIDTH-1:0] lane_q [COLS];

  for (genvar c = 0; c < COLS; c++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    lane_q[c] <= '0;
      else if (load_en_i)                             lane_q[c] <= load_line_i[c*WIDTH +: WIDTH];
      else if (wr_en_i && (wr_col_i == COL_W'(c)))    lane_q[c] <= wr_data_i;
    end
    assign line_o[c*WIDTH +: WIDTH] = lane_q[c];
  end

  assign rd_data_o = lane_q[rd_col_i];
endmodule

// File: rtl/dram_strobe_ctrl.sv
module dram_strobe_ctrl #(
  parameter int unsigned ROWS = 4,
  parameter int unsigned COLS = 4,
  localparam int unsigned ROW_W  = dram_page_pkg::idx_w(ROWS),
  localparam int unsigned COL_W  = dram_page_pkg::idx_w(COLS),
  localparam int unsigned ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              row_strobe_ni,
  input  logic              col_strobe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  output logic              load_en_o,
  output logic              wb_en_o,
  output logic [ROW_W-1:0]  open_row_o,
  output logic              buf_we_o,
  output logic [COL_W-1:0]  col_sel_o,
  output logic              col_active_o,
  output logic              row_open_o,
  output logic              err_o
);
  import dram_page_pkg::*;

  row_state_e state_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic col_hi_q, col_act_q, err_q;
  logic open, row_act, col_fall, col_ok;

  assign open     = (state_q == ROW_OPEN);
  assign row_act  = !row_strobe_ni;
  assign col_fall = !col_strobe_ni && col_hi_q;
  assign col_ok   = col_fall && open && row_act;

  assign load_en_o = !open && row_act;
  assign wb_en_o   = open && !row_act;
  assign buf_we_o  = col_ok && we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ROW_IDLE;
      row_q     <= '0;
      col_q     <= '0;
      col_hi_q  <= 1'b1;
      col_act_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      col_hi_q <= col_strobe_ni;
      if (load_en_o) begin
        state_q <= ROW_OPEN;
        row_q   <= addr_i[ROW_W-1:0];
      end else if (wb_en_o) begin
        state_q <= ROW_IDLE;
      end
      if (col_ok) col_q <= addr_i[COL_W-1:0];
      if (col_strobe_ni || wb_en_o) col_act_q <= 1'b0;
      else if (col_ok)              col_act_q <= 1'b1;
      // stray column strobe: flag it, touch nothing else
      if (col_fall && !col_ok) err_q <= 1'b1;
    end
  end

  assign open_row_o   = row_q;
  assign col_sel_o    = col_q;
  assign col_active_o = col_act_q;
  assign row_open_o   = open;
  assign err_o        = err_q;
endmodule

// File: rtl/dram_page_array.sv
module dram_page_array #(
  parameter int unsigned ROWS  = 4,
  parameter int unsigned COLS  = 4,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned ROW_W  = dram_page_pkg::idx_w(ROWS),
  localparam int unsigned COL_W  = dram_page_pkg::idx_w(COLS),
  localparam int unsigned ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W,
  localparam int unsigned LINE_W = COLS * WIDTH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              row_strobe_ni,
  input  logic              col_strobe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic [WIDTH-1:0]  rdata_o,
  output logic              proto_err_o
);
  logic              load_en, wb_en, buf_we, col_active, row_open;
  logic [ROW_W-1:0]  open_row;
  logic [COL_W-1:0]  col_sel;
  logic [LINE_W-1:0] arr_line, buf_line;
  logic [WIDTH-1:0]  buf_rd;

  dram_strobe_ctrl #(.ROWS(ROWS), .COLS(COLS)) u_ctrl (
    .clk_i, .rst_ni, .row_strobe_ni, .col_strobe_ni, .addr_i, .we_i,
    .load_en_o(load_en), .wb_en_o(wb_en), .open_row_o(open_row),
    .buf_we_o(buf_we), .col_sel_o(col_sel), .col_active_o(col_active),
    .row_open_o(row_open), .err_o(proto_err_o)
  );

  // load reads the row being opened straight off the bus
  dram_cell_array #(.ROWS(ROWS), .COLS(COLS), .WIDTH(WIDTH)) u_array (
    .clk_i, .rst_ni,
    .rd_row_i(addr_i[ROW_W-1:0]), .rd_line_o(arr_line),
    .wb_en_i(wb_en), .wb_row_i(open_row), .wb_line_i(buf_line)
  );

  dram_row_buffer #(.COLS(COLS), .WIDTH(WIDTH)) u_buf (
    .clk_i, .rst_ni,
    .load_en_i(load_en), .load_line_i(arr_line),
    .wr_en_i(buf_we), .wr_col_i(addr_i[COL_W-1:0]), .wr_data_i(wdata_i),
    .rd_col_i(col_sel), .rd_data_o(buf_rd), .line_o(buf_line)
  );

  assign rdata_o = col_active ? buf_rd : '0;
endmodule

// File: rtl/dram_page_chk.sv
module dram_page_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             row_strobe_ni,
  input logic             col_strobe_ni,
  input logic [WIDTH-1:0] rdata_o,
  input logic             proto_err_o,
  input logic             row_open
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  // R3
  col_idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_strobe_ni |=> (rdata_o == '0));

  // R2
  row_opens_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!row_strobe_ni && !row_open) |=> row_open);

  // R7
  row_closes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_strobe_ni && row_open) |=> !row_open);

  // R9
  stray_col_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !col_strobe_ni && $past(col_strobe_ni) && !row_open) |=> proto_err_o);

  // R10
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_err_o |=> proto_err_o);

  // R11
  held_col_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !col_strobe_ni && !$past(col_strobe_ni) && !row_strobe_ni && !$past(row_strobe_ni))
      |=> $stable(rdata_o));
endmodule

bind dram_page_array dram_page_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .row_strobe_ni(row_strobe_ni),
  .col_strobe_ni(col_strobe_ni), .rdata_o(rdata_o),
  .proto_err_o(proto_err_o), .row_open(row_open)
);

// File: tb/sim_dram_page_array.sv
module sim_dram_page_array;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 4, COLS = 4, WIDTH = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic row_n = 1'b1, col_n = 1'b1, we = 1'b0;
  logic [1:0] addr = '0;
  logic [WIDTH-1:0] wdata = '0, rdata;
  logic err;
  int n_run = 0, n_fail = 0;
  logic [WIDTH-1:0] exp_mem [ROWS][COLS];

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_page_array #(.ROWS(ROWS), .COLS(COLS), .WIDTH(WIDTH)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .row_strobe_ni(row_n), .col_strobe_ni(col_n),
    .addr_i(addr), .we_i(we), .wdata_i(wdata), .rdata_o(rdata), .proto_err_o(err)
  );

  task automatic check(input string req, input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic open_row(input int r);
    row_n = 1'b0; addr = 2'(r);
    @(negedge clk);
  endtask

  task automatic close_row();
    row_n = 1'b1;
    @(negedge clk);
  endtask

  // one column strobe; checks held data then idle zero
  task automatic col_cycle(input string req, input int c, input logic w,
                           input logic [WIDTH-1:0] d, input logic [WIDTH-1:0] exp);
    col_n = 1'b0; addr = 2'(c); we = w; wdata = d;
    @(negedge clk);
    we = 1'b0;
    check(req, rdata, exp);
    col_n = 1'b1;
    @(negedge clk);
    check("R3 idle zero", rdata, '0);
  endtask

  task automatic t_reset();
    check("R1 rdata", rdata, '0);
    check("R1 err", {7'b0, err}, 8'h0);
    open_row(3);
    col_cycle("R1 cleared word", 2, 1'b0, '0, 8'h00);
    close_row();
  endtask

  task automatic t_fill();
    for (int r = 0; r < ROWS; r++) begin
      open_row(r);
      for (int c = 0; c < COLS; c++) begin
        exp_mem[r][c] = 8'(8'hA0 + r*16 + c);
        col_cycle("R6 write shown", c, 1'b1, exp_mem[r][c], exp_mem[r][c]);
      end
      close_row();
    end
  endtask

  task automatic t_page_read(input string req);
    for (int r = ROWS-1; r >= 0; r--) begin
      open_row(r);
      for (int c = 0; c < COLS; c++)
        col_cycle(req, (c + r) % COLS, 1'b0, '0, exp_mem[r][(c + r) % COLS]);
      close_row();
    end
  endtask

  task automatic t_isolation();
    open_row(2);
    exp_mem[2][1] = 8'h3C;
    col_cycle("R6 overwrite", 1, 1'b1, 8'h3C, 8'h3C);
    col_cycle("R5 second access same page", 3, 1'b0, '0, exp_mem[2][3]);
    close_row();
    for (int r = 1; r <= 3; r++) begin
      open_row(r);
      for (int c = 0; c < COLS; c++)
        col_cycle("R8 isolation", c, 1'b0, '0, exp_mem[r][c]);
      close_row();
    end
  endtask

  task automatic t_hold();
    open_row(1);
    col_n = 1'b0; addr = 2'd2;
    @(negedge clk);
    check("R4 read", rdata, exp_mem[1][2]);
    addr = 2'd0;
    @(negedge clk);
    check("R11 held column", rdata, exp_mem[1][2]);
    @(negedge clk);
    check("R11 still held", rdata, exp_mem[1][2]);
    col_n = 1'b1;
    @(negedge clk);
    check("R3 released", rdata, '0);
    close_row();
  endtask

  task automatic t_stray();
    check("R10 err clear before", {7'b0, err}, 8'h0);
    col_n = 1'b0; addr = 2'd0; we = 1'b1; wdata = 8'h55;
    @(negedge clk);
    check("R9 no data", rdata, '0);
    check("R9 err set", {7'b0, err}, 8'h1);
    col_n = 1'b1; we = 1'b0;
    @(negedge clk);
    open_row(0);
    col_cycle("R9 storage untouched", 0, 1'b0, '0, exp_mem[0][0]);
    close_row();
    repeat (3) @(negedge clk);
    check("R10 err sticky", {7'b0, err}, 8'h1);
  endtask

  logic done = 1'b0;
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_page_read("R2 R5 R7 page read");
    t_isolation();
    t_hold();
    t_stray();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule